// File: doc/BRIEF.md
# Periodic Tick and Watchdog Timer

This block gives a chip two timing services from one free-running divider on the bus clock. The first is a periodic tick. The second is a watchdog that expects software to service it before a fixed number of ticks have passed. One byte-wide control/status register holds the following:
- the tick period selection;
- the tick flag and its interrupt enable;
- the watchdog enable;
- a write-only service strobe;
- an option bit for the external-interrupt trigger style. This bit is only stored and driven out on a pin.

The tick period is 2^(BASE_LOG2 + rate) bus clocks. Here `rate` is the two-bit period field. With the default BASE_LOG2 of 14, the four periods are 16384, 32768, 65536 and 131072 bus clocks. The watchdog counts ticks at the selected period. It raises a one-cycle reset request on the seventh tick without a service, so its timeout follows the period field. A service clears both the tick count and the divider. Because of this, the rate field only accepts a new value in a write that services the watchdog, or in the write in the very next cycle. The system reset controller that acts on the request is outside the block.

Top module: `rtiwd_timer`

## Requirements
- R1: After reset the register reads 0x03 (period field = 3, every other bit 0), and irq, rst_req and ext_trig_sel are 0.
- R2: Register layout: bits [1:0] period field, bit 2 watchdog enable, bit 3 trigger option, bit 4 service strobe, bit 5 unused, bit 6 interrupt enable, bit 7 tick flag. The tick flag is set 2^(BASE_LOG2+rate) bus clocks after a service write, and again at every such interval.
- R3: The tick flag is set at each period whether or not the interrupt enable is 1. irq is high exactly while both the flag and the enable are 1.
- R4: Writing 0 to bit 7 clears the flag and irq falls at once. Writing 1 to bit 7 leaves it unchanged. If a tick and a clearing write fall on the same edge, the flag stays set.
- R5: Bit 6 is read/write. Writing 0 to it clears the enable, and later ticks then raise no irq.
- R6: Writing 1 to bit 4 services the watchdog. It restarts the tick count and the divider. Bit 4 always reads 0.
- R7: With bit 2 set, rst_req goes high for exactly one bus clock, 7 × 2^(BASE_LOG2+rate) bus clocks after the last service write.
- R8: With bit 2 clear, rst_req stays 0.
- R9: The period field takes the written value only in a write that also sets bit 4, or in a write on the cycle right after such a write. In any other write the field keeps its old value.
- R10: Bit 3 is read/write and drives ext_trig_sel directly. Bit 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| irq | output | 1 | Periodic interrupt request |
| rst_req | output | 1 | One-cycle watchdog reset request |
| ext_trig_sel | output | 1 | Stored external-interrupt trigger option |

## Verification
The hardest case to reach from the ports is a flag-clearing write that lands on the same edge as a tick. Because of the set-wins rule, the flag should read 1 afterwards. The stimulus gets there by servicing the watchdog twice in a row. This puts the divider at a known zero, and no stale tick can fall on the edge that matters. The bench then counts exactly 2^(BASE_LOG2+rate) edges and places the clearing write on the tick edge. The same known-zero start lets the bench place the watchdog pulse to the cycle and confirm that a second service, issued mid-window, pushes that pulse out.

// File: rtl/rtiwd_pkg.sv
package rtiwd_pkg;

   localparam int REG_W   = 8;
   localparam int RATE_W  = 2;

   // bit positions inside the control/status byte
   localparam int B_RATE  = 0;
   localparam int B_WDEN  = 2;
   localparam int B_EXTT  = 3;
   localparam int B_SVC   = 4;
   localparam int B_IE    = 6;
   localparam int B_FLAG  = 7;

   localparam logic [RATE_W-1:0] RATE_RESET = '1;

   typedef struct packed {
      logic              flag;
      logic              ie;
      logic              ext;
      logic              wden;
      logic [RATE_W-1:0] rate;
   } ctl_t;

   function automatic logic [REG_W-1:0] ctl_to_byte(input ctl_t c);
      logic [REG_W-1:0] b;
      b                           = '0;
      b[B_RATE +: RATE_W]         = c.rate;
      b[B_WDEN]                   = c.wden;
      b[B_EXTT]                   = c.ext;
      b[B_IE]                     = c.ie;
      b[B_FLAG]                   = c.flag;
      return b;
   endfunction

endpackage

// File: rtl/rtiwd_divider.sv
module rtiwd_divider
   import rtiwd_pkg::*;
#(
   parameter int BASE_LOG2            = 14,
   parameter int DIV_LOG2             = 2,
   parameter bit CLEAR_DIV_ON_SERVICE = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   input  logic              svc,
   output logic              tick
);
   localparam int CNT_W = BASE_LOG2 + (2**RATE_W) - 1;

   if (BASE_LOG2 < DIV_LOG2 + 1) begin : g_bad_base
      $error("BASE_LOG2 must exceed the bus-clock pre-division stage");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   // selected period is 2**(BASE_LOG2+rate); mask covers its low bits
   always_comb begin
      mask = (CNT_W'(1) << (BASE_LOG2 + int'(rate))) - CNT_W'(1);
      tick = ((cnt & mask) == mask);
   end

   if (CLEAR_DIV_ON_SERVICE) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cnt <= '0;
         else if (svc) cnt <= '0;
         else          cnt <= cnt + CNT_W'(1);
      end

      p_div_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
         svc |=> (cnt == '0))
         else $error("divider not restarted by service");
   end else begin : g_free
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt <= '0;
         else        cnt <= cnt + CNT_W'(1);
      end
   end

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !svc) |=> !tick)
      else $error("tick held for more than one cycle");

endmodule

// File: rtl/rtiwd_watchdog.sv
module rtiwd_watchdog #(
   parameter int WD_W     = 3,
   parameter int WD_LIMIT = 7
)(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   input  logic svc,
   output logic rst_req
);
   if (WD_LIMIT < 2 || WD_LIMIT >= 2**WD_W) begin : g_bad_limit
      $error("WD_LIMIT must fit the period counter");
   end

   localparam logic [WD_W-1:0] LAST = WD_W'(WD_LIMIT - 1);

   logic [WD_W-1:0] periods;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         periods <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (svc || !en) begin
            periods <= '0;
         end else if (tick) begin
            if (periods == LAST) begin
               periods <= '0;
               rst_req <= 1'b1;
            end else begin
               periods <= periods + WD_W'(1);
            end
         end
      end
   end

   p_req_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req)
      else $error("reset request wider than one cycle");

   p_req_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(en))
      else $error("reset request while watchdog disabled");

   p_service_blocks_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      svc |=> !rst_req)
      else $error("reset request right after a service");

endmodule

// File: rtl/rtiwd_ctl_reg.sv
module rtiwd_ctl_reg
   import rtiwd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             tick,
   output ctl_t             ctl,
   output logic             svc
);
   logic svc_d;
   logic rate_ok;

   assign svc     = wr_en & wr_data[B_SVC];
   assign rate_ok = wr_data[B_SVC] | svc_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl.rate <= RATE_RESET;
         ctl.wden <= 1'b0;
         ctl.ext  <= 1'b0;
         ctl.ie   <= 1'b0;
         ctl.flag <= 1'b0;
         svc_d    <= 1'b0;
      end else begin
         svc_d <= svc;
         if (wr_en) begin
            ctl.wden <= wr_data[B_WDEN];
            ctl.ext  <= wr_data[B_EXTT];
            ctl.ie   <= wr_data[B_IE];
            if (rate_ok) ctl.rate <= wr_data[B_RATE +: RATE_W];
         end
         // a tick outranks a clearing write on the same edge
         if (tick)
            ctl.flag <= 1'b1;
         else if (wr_en && !wr_data[B_FLAG])
            ctl.flag <= 1'b0;
      end
   end

   p_rate_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctl.rate) |-> $past(wr_en && (wr_data[B_SVC] || svc_d)))
      else $error("period field changed outside the service window");

   p_flag_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.flag) |-> $past(tick))
      else $error("flag set without a tick");

endmodule

// File: rtl/rtiwd_timer.sv
module rtiwd_timer
   import rtiwd_pkg::*;
#(
   parameter int BASE_LOG2            = 14,
   parameter int DIV_LOG2             = 2,
   parameter int WD_W                 = 3,
   parameter int WD_LIMIT             = 7,
   parameter bit CLEAR_DIV_ON_SERVICE = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             irq,
   output logic             rst_req,
   output logic             ext_trig_sel
);
   ctl_t ctl;
   logic svc;
   logic tick;

   rtiwd_ctl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .tick    (tick),
      .ctl     (ctl),
      .svc     (svc)
   );

   rtiwd_divider #(
      .BASE_LOG2            (BASE_LOG2),
      .DIV_LOG2             (DIV_LOG2),
      .CLEAR_DIV_ON_SERVICE (CLEAR_DIV_ON_SERVICE)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .rate  (ctl.rate),
      .svc   (svc),
      .tick  (tick)
   );

   rtiwd_watchdog #(
      .WD_W     (WD_W),
      .WD_LIMIT (WD_LIMIT)
   ) u_wd (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .en      (ctl.wden),
      .svc     (svc),
      .rst_req (rst_req)
   );

   assign rd_data      = ctl_to_byte(ctl);
   assign irq          = ctl.flag & ctl.ie;
   assign ext_trig_sel = ctl.ext;

   p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[B_FLAG] && !tick) |=> !irq)
      else $error("irq survived a flag clear");

   p_svc_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      svc |=> (rd_data[B_SVC] == 1'b0))
      else $error("service bit read back as 1");

endmodule

// File: tb/sim_rtiwd_timer.sv
module sim_rtiwd_timer;
   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 4;
   localparam int NVEC       = 8;

   // {write data, expected read-back}
   localparam logic [15:0] VEC [NVEC] = '{
      16'h00_03,  // R9 rate write without service ignored
      16'h4C_4F,  // R5 R10 ie, trigger option, wd enable
      16'h11_01,  // R6 R9 service + new rate accepted, bit 4 reads 0
      16'h02_02,  // R9 cycle right after service still accepts
      16'h03_02,  // R9 not adjacent to service: rejected
      16'h28_0A,  // R10 bit 5 reads 0, trigger option stored
      16'h80_02,  // R4 writing 1 to flag has no effect
      16'h13_03   // R9 service + rate 3
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq, rst_req, ext_trig_sel;

   int checks = 0;
   int fails  = 0;
   int pulses = 0;
   int snap;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtiwd_timer #(.BASE_LOG2(BASE)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_data      (rd_data),
      .irq          (irq),
      .rst_req      (rst_req),
      .ext_trig_sel (ext_trig_sel)
   );

   always @(negedge clk) if (rst_req) pulses++;

   function automatic int per(input int r);
      return 1 << (BASE + r);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at negedge, captured at next posedge, return at following negedge
   task automatic wr(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 8'h00;
   endtask

   // two service writes: divider at a known zero from the second edge
   task automatic svc_wr(input logic [7:0] d);
      wr(d);
      wr(d);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog timeout");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reg", 32'(rd_data), 32'h03);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 rst_req", 32'(rst_req), 0);
      chk("R1 ext", 32'(ext_trig_sel), 0);

      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][15:8]);
         chk("R9/R10/R6 vec", 32'(rd_data), 32'(VEC[i][7:0]));
         chk("R10 ext pin", 32'(ext_trig_sel), 32'(VEC[i][3]));
      end

      // R2 R3: period per rate, flag without enable, no irq
      for (int r = 0; r < 4; r++) begin
         svc_wr(8'h10 | 8'(r));
         repeat (per(r) - 1) @(negedge clk);
         chk("R2 flag before period", 32'(rd_data[7]), 0);
         @(negedge clk);
         chk("R2 flag at period", 32'(rd_data[7]), 1);
         chk("R3 no irq when disabled", 32'(irq), 0);
      end

      // R3 R4 R5: interrupt path, rate 0
      svc_wr(8'h50);
      repeat (per(0)) @(negedge clk);
      chk("R3 irq raised", 32'(irq), 1);
      wr(8'h40);
      chk("R4 irq cleared", 32'(irq), 0);
      chk("R4 flag cleared", 32'(rd_data[7]), 0);
      wr(8'h00);
      chk("R5 ie cleared", 32'(rd_data[6]), 0);
      repeat (per(0)) @(negedge clk);
      chk("R5 flag set, no irq", 32'({rd_data[7], irq}), 32'b10);

      // R4: clearing write on the tick edge, flag stays set
      svc_wr(8'h10);
      repeat (per(0) - 1) @(negedge clk);
      wr(8'h00);
      chk("R4 set wins", 32'(rd_data[7]), 1);
      wr(8'h80);
      chk("R4 write 1 no effect", 32'(rd_data[7]), 1);

      // R7: timeout, rate 0
      svc_wr(8'h14);
      snap = pulses;
      repeat (7 * per(0) - 1) @(negedge clk);
      chk("R7 no early req", 32'(rst_req), 0);
      @(negedge clk);
      chk("R7 req at timeout", 32'(rst_req), 1);
      @(negedge clk);
      chk("R7 one cycle", 32'(rst_req), 0);
      chk("R7 single pulse", 32'(pulses - snap), 1);
      svc_wr(8'h10);

      // R6: mid-window service pushes the timeout
      svc_wr(8'h14);
      repeat (5 * per(0)) @(negedge clk);
      wr(8'h14);
      snap = pulses;
      repeat (7 * per(0) - 1) @(negedge clk);
      chk("R6 service restarted window", 32'(pulses - snap), 0);
      @(negedge clk);
      chk("R6 req after restarted window", 32'(rst_req), 1);
      svc_wr(8'h10);

      // R8: disabled watchdog stays quiet
      snap = pulses;
      repeat (10 * per(0)) @(negedge clk);
      chk("R8 no req when disabled", 32'(pulses - snap), 0);

      finish_run();
   end
endmodule